// File: doc/BRIEF.md
# Adaptive-Step Delta Modulation Speech Encoder

This block turns a stream of signed PCM speech samples into a one-bit-per-sample serial stream. Each time the sample strobe is high it compares the new sample with a local reconstruction held in an integrator. It sends out a 1 when the sample lies strictly above the reconstruction and a 0 otherwise. The same bit moves the integrator up or down, so the integrator follows the input. A far-end decoder that runs the same integrator rebuilds the signal from the bit stream alone.

The integrator moves by a step whose size adapts to signal level. The three most recent output bits are kept in a short history. When all three match, the integrator is lagging the input. That event feeds a leaky accumulator, the syllabic filter, which makes the step larger. When the runs stop, the accumulator decays and the step shrinks back toward a fixed floor. The integrator also loses a small fraction of its value every sample, so it drifts back toward zero. It saturates at the signed limits rather than wrapping. With a silent input the encoder settles into an alternating 1,0 pattern.

Each accepted sample produces one registered bit with its own valid strobe. The integrator value after the update is also registered and brought out. A decoder model or a bench can compare against it.

Top module: `cvsd_encoder`

## Requirements
- R1: For each accepted sample the output bit is 1 when the signed sample is strictly greater than the integrator value held before that sample, and 0 otherwise; an input equal to the integrator gives 0.
- R2: A sample is accepted only on a cycle with `smp_valid` high. `bit_valid` is high exactly one cycle later. Without a strobe, `bit_valid` is low and `bit_out` and `recon` keep their values.
- R3: The history holds the three most recent output bits, including the current one. Coincidence is true for that sample when all three are 1 or all three are 0.
- R4: On each accepted sample the syllabic accumulator S (unsigned) becomes S - (S >> 5), plus 512 when coincidence is true. Its effect is seen through later step sizes.
- R5: The step applied on a sample is min(S + 64, 4096), using S from before that sample. It is added to the integrator when the bit is 1 and subtracted when it is 0.
- R6: Before the step is applied, the integrator X is leaked to X - (X >>> 6), an arithmetic shift.
- R7: The new integrator value saturates to the range -32768..32767 and never wraps.
- R8: With a constant zero input, the output settles into strict 1,0 alternation.
- R9: A synchronous active-high reset clears the integrator, the accumulator, the history, `bit_out` and `bit_valid` to zero. A strobe during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: sample present |
| smp_data | input | 16 | Signed PCM sample |
| bit_valid | output | 1 | Registered strobe: new bit present |
| bit_out | output | 1 | Registered encoded bit |
| recon | output | 16 | Registered signed integrator value after the last sample |

## Verification
The first test is a short ramp from reset with hand-computed integrator values. It separates the order of leak and step from coincidence timing and the step floor. A constant zero input shows the tie rule at the first sample and the settled 1,0 alternation. Full-scale positive and negative inputs push the step to its cap and the integrator into both saturation limits, which exposes wrapping. A slow triangle input, fed both back-to-back and with idle gaps, is checked against a model built from the requirements. It separates step tracking from any state change on idle cycles. A reset in mid-stream checks that the reset wins over a strobe on the same cycle.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  // Default sizing shared by the encoder and its parts
  localparam int unsigned CVSD_DW        = 16;   // sample / integrator width
  localparam int unsigned CVSD_HIST      = 3;    // run-length history depth
  localparam int unsigned CVSD_SW        = 16;   // syllabic accumulator width
  localparam int unsigned CVSD_SYL_SHIFT = 5;    // syllabic decay shift
  localparam int unsigned CVSD_LEAK      = 6;    // integrator leak shift
  localparam int unsigned CVSD_SYL_INC   = 512;  // charge per coincidence
  localparam int unsigned CVSD_STEP_MIN  = 64;   // step floor
  localparam int unsigned CVSD_STEP_MAX  = 4096; // step cap
endpackage

// File: rtl/cvsd_history.sv
module cvsd_history #(
  parameter int unsigned HW = cvsd_pkg::CVSD_HIST
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_in,
  output logic coinc
);
  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_n;

  generate
    if (HW > 1) begin : g_shift
      assign hist_n = {hist_q[HW-2:0], bit_in};
    end else begin : g_single
      assign hist_n = bit_in;
    end
  endgenerate

  // run of identical bits including the present one
  assign coinc = (&hist_n) | (~|hist_n);

  always_ff @(posedge clk) begin
    if (rst)     hist_q <= '0;
    else if (en) hist_q <= hist_n;
  end
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
  parameter int unsigned SW       = cvsd_pkg::CVSD_SW,
  parameter int unsigned DW       = cvsd_pkg::CVSD_DW,
  parameter int unsigned SHIFT    = cvsd_pkg::CVSD_SYL_SHIFT,
  parameter int unsigned INC      = cvsd_pkg::CVSD_SYL_INC,
  parameter int unsigned STEP_MIN = cvsd_pkg::CVSD_STEP_MIN,
  parameter int unsigned STEP_MAX = cvsd_pkg::CVSD_STEP_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          coinc,
  output logic [DW-1:0] step
);
  localparam int unsigned TW = SW + 1;

  logic [SW-1:0] syl_q;
  logic [SW-1:0] syl_n;
  logic [TW-1:0] floor_sum;
  logic [TW-1:0] capped;

  assign syl_n     = syl_q - (syl_q >> SHIFT) + (coinc ? SW'(INC) : '0);
  assign floor_sum = {1'b0, syl_q} + TW'(STEP_MIN);
  assign capped    = (floor_sum > TW'(STEP_MAX)) ? TW'(STEP_MAX) : floor_sum;
  assign step      = DW'(capped);

  always_ff @(posedge clk) begin
    if (rst)     syl_q <= '0;
    else if (en) syl_q <= syl_n;
  end
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
  parameter int unsigned DW   = cvsd_pkg::CVSD_DW,
  parameter int unsigned LEAK = cvsd_pkg::CVSD_LEAK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 up,
  input  logic [DW-1:0]        step,
  output logic signed [DW-1:0] x
);
  localparam int unsigned EW = DW + 2;
  localparam logic signed [EW-1:0] POS_LIM = EW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM - EW'(1);

  logic signed [EW-1:0] x_ext;
  logic signed [EW-1:0] leaked;
  logic signed [EW-1:0] step_ext;
  logic signed [EW-1:0] sum;
  logic signed [DW-1:0] x_n;

  always_comb begin
    x_ext    = {{2{x[DW-1]}}, x};
    leaked   = x_ext - (x_ext >>> LEAK);
    step_ext = {2'b00, step};
    sum      = up ? (leaked + step_ext) : (leaked - step_ext);
    if (sum > POS_LIM)      x_n = POS_LIM[DW-1:0];
    else if (sum < NEG_LIM) x_n = NEG_LIM[DW-1:0];
    else                    x_n = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     x <= '0;
    else if (en) x <= x_n;
  end
endmodule

// File: rtl/cvsd_encoder.sv
module cvsd_encoder #(
  parameter int unsigned DW        = cvsd_pkg::CVSD_DW,
  parameter int unsigned HW        = cvsd_pkg::CVSD_HIST,
  parameter int unsigned SW        = cvsd_pkg::CVSD_SW,
  parameter int unsigned SYL_SHIFT = cvsd_pkg::CVSD_SYL_SHIFT,
  parameter int unsigned LEAK      = cvsd_pkg::CVSD_LEAK,
  parameter int unsigned SYL_INC   = cvsd_pkg::CVSD_SYL_INC,
  parameter int unsigned STEP_MIN  = cvsd_pkg::CVSD_STEP_MIN,
  parameter int unsigned STEP_MAX  = cvsd_pkg::CVSD_STEP_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          bit_valid,
  output logic          bit_out,
  output logic [DW-1:0] recon
);
  logic                 dec;
  logic                 coinc;
  logic [DW-1:0]        step;
  logic signed [DW-1:0] integ;

  // comparator: strict greater-than, tie gives 0
  assign dec = $signed(smp_data) > integ;

  cvsd_history #(.HW(HW)) u_hist (
    .clk(clk), .rst(rst), .en(smp_valid), .bit_in(dec), .coinc(coinc)
  );

  cvsd_syllabic #(
    .SW(SW), .DW(DW), .SHIFT(SYL_SHIFT), .INC(SYL_INC),
    .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
  ) u_syl (
    .clk(clk), .rst(rst), .en(smp_valid), .coinc(coinc), .step(step)
  );

  cvsd_integrator #(.DW(DW), .LEAK(LEAK)) u_integ (
    .clk(clk), .rst(rst), .en(smp_valid), .up(dec), .step(step), .x(integ)
  );

  assign recon = integ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= smp_valid;
      if (smp_valid) bit_out <= dec;
    end
  end
endmodule

// File: rtl/cvsd_encoder_chk.sv
module cvsd_encoder_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          bit_valid,
  input logic          bit_out,
  input logic [DW-1:0] recon
);
  localparam logic signed [DW-1:0] HALF_POS = DW'(64'sd1 <<< (DW-2));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> bit_valid);                                           // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!bit_valid && $stable(recon) && $stable(bit_out))); // R2
  AST_BIT_SIGN: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (bit_out == ($signed($past(smp_data)) > $signed($past(recon))))); // R1
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_out && $signed($past(recon)) >= HALF_POS) |-> $signed(recon) > 0); // R7
  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_out && $signed($past(recon)) <= -HALF_POS) |-> $signed(recon) < 0); // R7
endmodule

bind cvsd_encoder cvsd_encoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
  .bit_valid(bit_valid), .bit_out(bit_out), .recon(recon)
);

// File: tb/cvsd_encoder_tb.sv
module cvsd_encoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        bit_valid;
  logic        bit_out;
  logic [15:0] recon;

  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  int       m_x;
  int       m_s;
  bit [2:0] m_h;

  always #10 clk = ~clk;

  cvsd_encoder u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .bit_valid(bit_valid), .bit_out(bit_out), .recon(recon)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_x = 0; m_s = 0; m_h = 3'b000;
  endtask

  task automatic model_step(input int smp, output bit b);
    int st;
    int nx;
    bit co;
    b   = smp > m_x;                                   // R1
    m_h = {m_h[1:0], b};                               // R3
    co  = (m_h == 3'b111) || (m_h == 3'b000);
    st  = m_s + 64; if (st > 4096) st = 4096;          // R5
    m_s = m_s - (m_s >> 5) + (co ? 512 : 0);           // R4
    nx  = m_x - (m_x >>> 6);                           // R6
    nx  = b ? nx + st : nx - st;
    if (nx > 32767) nx = 32767;                        // R7
    if (nx < -32768) nx = -32768;
    m_x = nx;
  endtask

  // one sample with an idle cycle after it; checked against the model
  task automatic push(input int smp, input string req, output bit b);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 16'(smp);
    model_step(smp, b);
    @(negedge clk);
    smp_valid = 1'b0;
    chk({req, " valid"}, int'(bit_valid), 1);
    chk({req, " bit"},   int'(bit_out), int'(b));
    chk({req, " recon"}, int'($signed(recon)), m_x);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; smp_valid = 1'b1; smp_data = 16'sd1000;
    @(negedge clk); rst = 1'b0; smp_valid = 1'b0;
    model_reset();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R9 reset bit_valid", int'(bit_valid), 0);
    chk("R9 reset bit_out",   int'(bit_out), 0);
    chk("R9 reset recon",     int'($signed(recon)), 0);
  endtask

  task automatic t_first_steps();
    bit b;
    do_reset();
    push(1000, "R5 floor step", b);     chk("R5 x1", int'($signed(recon)), 64);
    push(1000, "R6 leak", b);           chk("R6 x2", int'($signed(recon)), 127);
    push(1000, "R3 run of three", b);   chk("R3 x3", int'($signed(recon)), 190);
    push(1000, "R4 charged step", b);   chk("R4 x4", int'($signed(recon)), 764);
  endtask

  task automatic t_zero_input();
    bit b;
    bit prev;
    do_reset();
    push(0, "R1 tie", b);
    chk("R1 tie gives 0", int'(bit_out), 0);
    for (int i = 0; i < 400; i++) begin
      push(0, "R8 zero", b);
      if (i >= 380) chk("R8 alternation", int'(bit_out), int'(!prev));
      prev = bit_out;
    end
  endtask

  task automatic t_full_scale();
    bit b;
    int mx = -40000;
    do_reset();
    for (int i = 0; i < 80; i++) begin
      push(32767, "R7 pos", b);
      if ($signed(recon) > mx) mx = $signed(recon);
    end
    chk("R7 reached positive limit", mx, 32767);
    for (int i = 0; i < 80; i++) push(-32768, "R7 neg", b);
    chk("R7 held at negative limit", int'($signed(recon)), -32768);
    chk("R1 below limit gives 0", int'(bit_out), 0);
  endtask

  task automatic t_triangle_gaps();
    bit b;
    int v = 0;
    int d = 700;
    logic [15:0] hold_r;
    logic        hold_b;
    do_reset();
    for (int i = 0; i < 120; i++) begin
      v += d;
      if (v > 20000 || v < -20000) d = -d;
      push(v, "R5 triangle", b);
      if (i % 17 == 0) begin
        hold_r = recon; hold_b = bit_out;
        repeat (4) begin
          @(negedge clk);
          chk("R2 idle valid low", int'(bit_valid), 0);
          chk("R2 idle recon held", int'(recon), int'(hold_r));
          chk("R2 idle bit held", int'(bit_out), int'(hold_b));
        end
      end
    end
  endtask

  task automatic t_burst();
    bit b;
    bit pb;
    do_reset();
    for (int i = 0; i <= 40; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 burst valid", int'(bit_valid), 1);
        chk("R2 burst bit", int'(bit_out), int'(pb));
        chk("R4 burst recon", int'($signed(recon)), m_x);
      end
      if (i < 40) begin
        smp_valid = 1'b1; smp_data = 16'((i % 8) * 3000 - 9000);
        model_step((i % 8) * 3000 - 9000, b);
        pb = b;
      end else smp_valid = 1'b0;
    end
    @(negedge clk);
    chk("R2 burst end", int'(bit_valid), 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset_state();
    t_first_steps();
    t_zero_input();
    t_full_scale();
    t_triangle_gaps();
    t_burst();
    t_reset_state();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule